// File: doc/BRIEF.md
# Known-Defect Bit Repair with Pointer Table

This block keeps one memory block of 512 bits usable after some of its cells have worn out and stick at a fixed value. A controller that has found a dead cell reports its bit position, and the block stores that position in a small table. Each table entry holds one spare storage bit that stands in for the dead cell. The table has six entries by default, and the entry count is a parameter.

Every write to the memory block also passes through this block. For each entry in use, the block copies the data bit at the recorded position into that entry's spare bit. Every read passes the raw word from the array through the block, which puts each spare bit back at its recorded position. The bulk array sits outside the block. Faults are only repaired at positions that have been reported; the block never searches for faults of its own accord.

Top module: `ecpRepair`

## Requirements
- R1: After reset no entry is in use, `usedCount` is 0, `tableFull` is 0, and `rdData` equals `rdRaw`.
- R2: Each `failEn` pulse that arrives while a free entry exists takes the lowest free entry, in order from entry 0 up to entry ENTRIES-1. `usedCount` rises by one on the following clock edge.
- R3: On a clock edge with `wrEn` high, every entry in use loads its spare bit with `wrData` at that entry's recorded position.
- R4: `rdData` is combinational from `rdRaw`. Each bit position recorded in an entry in use returns that entry's spare bit, so data written across stuck cells at recorded positions reads back intact.
- R5: Bit positions not recorded in any entry in use pass from `rdRaw` to `rdData` unchanged. Entries that are not in use have no effect, even though their pointer resets to position 0.
- R6: When two entries in use record the same position, the entry with the higher index supplies the read bit.
- R7: A newly taken entry starts with its spare bit at 0. When `wrEn` is high in the same cycle, the spare bit instead starts with `wrData` at `failPos`.
- R8: A `failEn` pulse while all entries are in use changes no entry and leaves `usedCount` unchanged. It sets `tableFull`, which then stays at 1 until reset.
- R9: Pointers cover the whole block, including bit positions 0 and DATA_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the memory block |
| wrData | input | 512 | Data being written to the array |
| rdRaw | input | 512 | Raw word read from the array |
| rdData | output | 512 | Repaired read word |
| failEn | input | 1 | Report a newly found dead cell |
| failPos | input | 9 | Bit position of the reported dead cell |
| usedCount | output | 3 | Number of table entries in use |
| tableFull | output | 1 | Sticky flag: a report arrived with no free entry |

## Verification
The bench places cells stuck at the value opposite to the written data at positions 0, 511 and in the middle. A design with a wrong index, or one that misses a table end, returns the stuck value instead of the written bit. A stuck cell that is never reported must show through unchanged, which catches a design whose unused entries, with their pointers reset to 0, still override bit 0. A repeated report of one position checks the read precedence: a design that favours the lower entry returns a stale 1 where 0 is expected. Reports with and without a write in the same cycle check how a new spare bit starts. A seventh report checks that a full table neither overwrites an entry nor lets `usedCount` wrap, and that the full flag stays set.

// File: rtl/ecpRepair_pkg.sv
package ecpRepair_pkg;

  // Strobes from control to datapath for the current cycle
  typedef struct packed {
    logic sparesLoad;      // capture data bits into spares of entries in use
    logic entryAlloc;      // one entry takes the reported position
    logic allocFromWrite;  // the new entry also sees a write this cycle
  } ecpStrobe_t;

endpackage

// File: rtl/ecpCtrl.sv
module ecpCtrl
  import ecpRepair_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               failEn,
  output ecpStrobe_t         strobe,
  output logic [ENTRIES-1:0] allocSel,
  output logic [ENTRIES-1:0] validVec,
  output logic [CNT_W-1:0]   usedCount,
  output logic               tableFull
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ENTRIES);

  logic [CNT_W-1:0] countQ;
  logic             fullQ;
  logic             hasRoom;
  logic             doAlloc;

  assign hasRoom = (countQ != LAST_CNT);
  assign doAlloc = failEn && hasRoom;

  always_comb begin
    strobe                = '0;
    strobe.sparesLoad     = wrEn;
    strobe.entryAlloc     = doAlloc;
    strobe.allocFromWrite = doAlloc && wrEn;
  end

  // Entry state derived from the fill level: entries fill in index order
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entryState
    assign validVec[e] = (countQ > CNT_W'(e));
    assign allocSel[e] = doAlloc && (countQ == CNT_W'(e));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      fullQ  <= 1'b0;
    end else begin
      if (doAlloc) countQ <= countQ + CNT_W'(1);
      if (failEn && !hasRoom) fullQ <= 1'b1;
    end
  end

  assign usedCount = countQ;
  assign tableFull = fullQ;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (failEn && usedCount != LAST_CNT) |=> (usedCount == $past(usedCount) + CNT_W'(1)));

  assert_alloc_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(allocSel));

  assert_full_raise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (failEn && usedCount == LAST_CNT) |=> (tableFull && $stable(usedCount)));

  assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    tableFull |=> tableFull);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    usedCount <= LAST_CNT);

endmodule

// File: rtl/ecpDatapath.sv
module ecpDatapath
  import ecpRepair_pkg::*;
#(
  parameter int DATA_W  = 512,
  parameter int ENTRIES = 6,
  parameter int PTR_W   = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ecpStrobe_t         strobe,
  input  logic [ENTRIES-1:0] allocSel,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [PTR_W-1:0]   failPos,
  input  logic [DATA_W-1:0]  rdRaw,
  output logic [DATA_W-1:0]  rdData
);

  logic [PTR_W-1:0]   ptrQ [ENTRIES];
  logic [ENTRIES-1:0] spareQ;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic takeNew;
    assign takeNew = allocSel[e] && strobe.entryAlloc;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrQ[e]   <= '0;
        spareQ[e] <= 1'b0;
      end else if (takeNew) begin
        ptrQ[e]   <= failPos;
        spareQ[e] <= strobe.allocFromWrite ? wrData[failPos] : 1'b0;
      end else if (strobe.sparesLoad && validVec[e]) begin
        spareQ[e] <= wrData[ptrQ[e]];
      end
    end

    assert_spare_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.sparesLoad && validVec[e] && !allocSel[e])
        |=> (spareQ[e] == $past(wrData[ptrQ[e]])));

    assert_new_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
      allocSel[e] |=> ((ptrQ[e] == $past(failPos)) &&
        (spareQ[e] == ($past(strobe.allocFromWrite) ? $past(wrData[failPos]) : 1'b0))));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      (!validVec[e] && !allocSel[e]) |=> $stable(spareQ[e]));
  end

  // Later entries are applied last, so the highest index wins a shared position
  always_comb begin
    rdData = rdRaw;
    for (int e = 0; e < ENTRIES; e++) begin
      if (validVec[e]) rdData[ptrQ[e]] = spareQ[e];
    end
  end

endmodule

// File: rtl/ecpRepair.sv
module ecpRepair
  import ecpRepair_pkg::*;
#(
  parameter int DATA_W  = 512,
  parameter int ENTRIES = 6,
  localparam int PTR_W  = $clog2(DATA_W),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rdRaw,
  output logic [DATA_W-1:0] rdData,
  input  logic              failEn,
  input  logic [PTR_W-1:0]  failPos,
  output logic [CNT_W-1:0]  usedCount,
  output logic              tableFull
);

  ecpStrobe_t         strobe;
  logic [ENTRIES-1:0] allocSel;
  logic [ENTRIES-1:0] validVec;

  ecpCtrl #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .failEn    (failEn),
    .strobe    (strobe),
    .allocSel  (allocSel),
    .validVec  (validVec),
    .usedCount (usedCount),
    .tableFull (tableFull)
  );

  ecpDatapath #(.DATA_W(DATA_W), .ENTRIES(ENTRIES), .PTR_W(PTR_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .allocSel (allocSel),
    .validVec (validVec),
    .wrData   (wrData),
    .failPos  (failPos),
    .rdRaw    (rdRaw),
    .rdData   (rdData)
  );

  assert_empty_after_reset_R1: assert property (@(posedge clk)
    !rstN |=> (usedCount == '0 && !tableFull));

endmodule

// File: tb/ecpRepair_tb_top.sv
`timescale 1ns/1ps
module ecpRepair_tb_top;
  localparam int DW = 512;
  localparam int PW = 9;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN, wrEn, failEn, tableFull;
  logic [DW-1:0] wrData, rdData, rdRaw, memQ, stuckMask, stuckVal;
  logic [PW-1:0] failPos;
  logic [CW-1:0] usedCount;
  int nChecks = 0;
  int nFails  = 0;

  // Array model: cells in stuckMask always read their stuck value
  always_ff @(posedge clk) begin
    if (!rstN) memQ <= '0;
    else if (wrEn) memQ <= wrData;
  end
  assign rdRaw = (memQ & ~stuckMask) | (stuckVal & stuckMask);

  ecpRepair dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdRaw(rdRaw),
    .rdData(rdData), .failEn(failEn), .failPos(failPos),
    .usedCount(usedCount), .tableFull(tableFull)
  );

  task automatic chkVec(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkInt(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; failEn = 1'b0; wrData = '0; failPos = '0;
    stuckMask = '0; stuckVal = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setStuck(input int pos, input logic val);
    stuckMask[pos] = 1'b1;
    stuckVal[pos]  = val;
  endtask

  task automatic doWrite(input logic [DW-1:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doFail(input int pos);
    @(negedge clk); failEn = 1'b1; failPos = PW'(pos);
    @(negedge clk); failEn = 1'b0;
  endtask

  task automatic doWriteFail(input logic [DW-1:0] d, input int pos);
    @(negedge clk); wrEn = 1'b1; wrData = d; failEn = 1'b1; failPos = PW'(pos);
    @(negedge clk); wrEn = 1'b0; failEn = 1'b0;
  endtask

  // R1 and R5: empty table, unreported stuck cell shows through
  task automatic testReset();
    logic [DW-1:0] d, exp;
    applyReset();
    chkInt("R1 usedCount", int'(usedCount), 0);
    chkInt("R1 tableFull", int'(tableFull), 0);
    d = {16{32'h5A3C_96E1}};
    d[0] = 1'b1;
    doWrite(d);
    chkVec("R1 pass-through", rdData, d);
    setStuck(0, 1'b0);
    exp = d; exp[0] = 1'b0;
    #0.1;
    chkVec("R5 unreported stuck cell, unused entries ignored", rdData, exp);
  endtask

  // R2, R3, R4, R9: repair at both ends and the middle
  task automatic testRepair();
    logic [DW-1:0] d;
    applyReset();
    setStuck(0, 1'b1); setStuck(511, 1'b0); setStuck(100, 1'b1);
    doFail(0);
    chkInt("R2 count after first report", int'(usedCount), 1);
    doFail(511);
    doFail(100);
    chkInt("R2 count after three reports", int'(usedCount), 3);
    d = {16{32'hC3A5_0F78}};
    d[0] = 1'b0; d[511] = 1'b1; d[100] = 1'b0;
    doWrite(d);
    chkVec("R3 R4 R9 repaired read", rdData, d);
    d = ~d;
    d[0] = 1'b0; d[511] = 1'b1; d[100] = 1'b0; d[300] = 1'b1;
    doWrite(d);
    chkVec("R3 R4 second pattern", rdData, d);
    setStuck(300, 1'b0);
    d[300] = 1'b0;
    #0.1;
    chkVec("R5 other positions untouched", rdData, d);
  endtask

  // R6: duplicate pointers, higher index wins
  task automatic testDuplicate();
    logic [DW-1:0] d;
    applyReset();
    setStuck(37, 1'b0);
    doFail(37);
    d = {16{32'h0123_4567}};
    d[37] = 1'b1;
    doWrite(d);
    chkInt("R4 single entry bit", int'(rdData[37]), 1);
    doFail(37);
    chkInt("R6 higher entry wins (fresh spare 0)", int'(rdData[37]), 0);
    doWrite(d);
    chkInt("R6 both entries refreshed", int'(rdData[37]), 1);
  endtask

  // R7: new entry initial spare value
  task automatic testNewEntry();
    logic [DW-1:0] d;
    applyReset();
    setStuck(250, 1'b0); setStuck(251, 1'b0);
    d = '0; d[250] = 1'b1; d[251] = 1'b1;
    doWriteFail(d, 250);
    chkInt("R7 same-cycle write seeds spare", int'(rdData[250]), 1);
    doFail(251);
    chkInt("R7 report alone starts spare at 0", int'(rdData[251]), 0);
    doWrite(d);
    chkVec("R3 later write repairs both", rdData, d);
  endtask

  // R8: overflow of the table
  task automatic testOverflow();
    logic [DW-1:0] d;
    applyReset();
    for (int p = 10; p < 16; p++) begin
      setStuck(p, 1'b0);
      doFail(p);
    end
    chkInt("R2 count at capacity", int'(usedCount), 6);
    chkInt("R8 not full at capacity", int'(tableFull), 0);
    setStuck(20, 1'b0);
    doFail(20);
    chkInt("R8 full raised", int'(tableFull), 1);
    chkInt("R8 count held", int'(usedCount), 6);
    d = {16{32'hFFFF_0000}};
    for (int p = 10; p < 16; p++) d[p] = 1'b1;
    d[20] = 1'b1;
    doWrite(d);
    chkVec("R8 entries unchanged, extra position unrepaired", rdData, d & ~(DW'(1) << 20));
    doWrite('0);
    chkInt("R8 full sticky", int'(tableFull), 1);
    applyReset();
    chkInt("R1 full cleared by reset", int'(tableFull), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; failEn = 1'b0; wrData = '0; failPos = '0;
    stuckMask = '0; stuckVal = '0;
    testReset();
    testRepair();
    testDuplicate();
    testNewEntry();
    testOverflow();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule